// File: doc/BRIEF.md
# Framebuffer Control, Status and Vertical-Sync Interrupt Bank

This block holds the byte-wide control and status registers of a simple framebuffer controller. It answers a sixteen-byte window of a byte-addressed register bus, from offset 0x10 to 0x1F. The display path sends a single-cycle frame-done pulse at the end of every frame. When the interrupt-enable bit in the control byte is set, that pulse latches a pending flag, and the pending flag drives a level interrupt line.

Software acknowledges the interrupt by writing any value to the status byte. A status read returns the live pending flag together with fixed identification bits: a monitor-sense code and a colour-board marker. The remaining offsets of the window are plain byte registers for cursor and video settings, which the display path reads. Read data is registered: it appears on the bus one cycle after the request and holds until the next read.

Top module: `fbc_regbank`

## Requirements
- R1: While reset is active and afterwards until the first access, `irq` is 0, offset 0x10 reads 0x00, offset 0x11 reads 0x61 and offsets 0x12 to 0x1F read 0x00. A reset taken while an interrupt is pending drops `irq` at once.
- R2: Offset 0x10 is the control byte. A write stores all eight bits, and a read returns the byte last written.
- R3: A `frame_done` pulse in a cycle where control bit 7 is 1 sets the pending flag. `irq` is 1 from the next cycle on.
- R4: A `frame_done` pulse while control bit 7 is 0 changes neither `irq` nor the status read value.
- R5: A write of any data to offset 0x11 clears the pending flag, and `irq` is 0 from the next cycle on. The written data is not stored: afterwards the status byte reads 0x61.
- R6: A read of offset 0x11 returns bit 7 equal to the pending flag, bits 6 and 5 equal to 1, bit 0 equal to 1 and the other bits 0, so it returns 0xE1 or 0x61. A read has no side effect on the flag or on `irq`.
- R7: Offsets 0x12 to 0x1F are fourteen independent byte registers. Each returns the value last written to it, and a write to one leaves every other register unchanged.
- R8: When a `frame_done` pulse with control bit 7 at 1 and a status write fall in the same cycle, the pending flag is set and `irq` is 1 in the next cycle.
- R9: Accesses to offsets outside 0x10 to 0x1F read 0x00, and writes there change no register.
- R10: `bus_rdata` is loaded only by a read request (`bus_sel`=1, `bus_we`=0) and is valid in the cycle after it. Between reads it holds its value, whatever writes occur.
- R11: A control write in the same cycle as `frame_done` does not take effect for that pulse. The control bit 7 held before the cycle decides whether the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| frame_done | input | 1 | Single-cycle end-of-frame pulse from the display path |
| irq | output | 1 | Level interrupt, high while an interrupt is pending |

## Verification
A corrupted pending flag shows up at the ports one cycle after the event that set or cleared it. It appears both on `irq` and on bit 7 of the next status read. A wrong control byte or cursor byte is only visible through a read, so the bench compares `bus_rdata` and `irq` against a behavioural model on every clock under random traffic. Any divergence is therefore reported within one cycle of the read that exposes it. Directed sequences place a status write, a control write and a frame pulse in the same cycle, to catch errors in the priority between them.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned IE_BIT    = 7;
  localparam int unsigned PEND_BIT  = 7;
  // fixed identification bits merged into every status read
  localparam logic [BYTE_W-1:0] STAT_ID = 8'h61;

  typedef logic [BYTE_W-1:0] fbc_byte_t;

  // window slots with dedicated behaviour
  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_STAT = 2'd1
  } fbc_slot_e;
endpackage

// File: rtl/fbc_decode.sv
module fbc_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 16,
  parameter int unsigned WIN    = 16,
  parameter int unsigned FIRST  = 2,
  localparam int unsigned IDX_W = $clog2(WIN),
  localparam int unsigned NGEN  = WIN - FIRST
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_req,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic [NGEN-1:0]   wr_gen
);
  localparam logic [ADDR_W-IDX_W-1:0] WIN_TAG = (ADDR_W-IDX_W)'(BASE >> IDX_W);

  logic wr_hit;

  always_comb begin
    in_win  = (addr[ADDR_W-1:IDX_W] == WIN_TAG);
    idx     = addr[IDX_W-1:0];
    rd_req  = sel && !we;
    wr_hit  = sel && we && in_win;
    wr_ctrl = wr_hit && (idx == IDX_W'(fbc_pkg::SLOT_CTRL));
    wr_stat = wr_hit && (idx == IDX_W'(fbc_pkg::SLOT_STAT));
  end

  for (genvar g = 0; g < NGEN; g++) begin : g_gen_wr
    assign wr_gen[g] = wr_hit && (idx == IDX_W'(g + FIRST));
  end
endmodule

// File: rtl/fbc_irq_ctrl.sv
module fbc_irq_ctrl
  import fbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_ctrl,
  input  logic      wr_stat,
  input  fbc_byte_t wdata,
  input  logic      frame_done,
  output fbc_byte_t ctrl_q,
  output logic      pend_q
);
  fbc_byte_t ctrl_d;
  logic      ctrl_en;
  logic      pend_d;
  logic      pend_en;
  logic      raise;

  // next state
  always_comb begin
    ctrl_en = wr_ctrl;
    ctrl_d  = wdata;
    // enable sampled from the byte held before this cycle
    raise   = frame_done && ctrl_q[IE_BIT];
    pend_en = raise || wr_stat;
    // a new event outranks a simultaneous acknowledge
    pend_d  = raise;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/fbc_byte_bank.sv
module fbc_byte_bank
  import fbc_pkg::*;
#(
  parameter int unsigned NGEN = 14
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic [NGEN-1:0] wr_en,
  input  fbc_byte_t wdata,
  output fbc_byte_t bytes_q [NGEN]
);
  for (genvar g = 0; g < NGEN; g++) begin : g_byte
    fbc_byte_t d;
    logic      en;

    always_comb begin
      en = wr_en[g];
      d  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_q[g] <= '0;
      end else if (en) begin
        bytes_q[g] <= d;
      end
    end
  end
endmodule

// File: rtl/fbc_regbank.sv
module fbc_regbank
  import fbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 16,
  parameter int unsigned WIN    = 16,
  localparam int unsigned FIRST = 2,
  localparam int unsigned IDX_W = $clog2(WIN),
  localparam int unsigned NGEN  = WIN - FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              frame_done,
  output logic              irq
);
  logic            in_win;
  logic [IDX_W-1:0] idx;
  logic            rd_req;
  logic            wr_ctrl;
  logic            wr_stat;
  logic [NGEN-1:0] wr_gen;
  fbc_byte_t       ctrl_q;
  logic            pend_q;
  fbc_byte_t       gen_q [NGEN];
  fbc_byte_t       rd_val;
  fbc_byte_t       stat_view;
  fbc_byte_t       rdata_q;

  fbc_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .WIN(WIN), .FIRST(FIRST)
  ) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .in_win(in_win), .idx(idx), .rd_req(rd_req),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_gen(wr_gen)
  );

  fbc_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wdata(bus_wdata),
    .frame_done(frame_done),
    .ctrl_q(ctrl_q), .pend_q(pend_q)
  );

  fbc_byte_bank #(.NGEN(NGEN)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_gen), .wdata(bus_wdata),
    .bytes_q(gen_q)
  );

  // read selection
  always_comb begin
    stat_view = STAT_ID;
    stat_view[PEND_BIT] = pend_q;
    rd_val = '0;
    if (in_win) begin
      if (idx == IDX_W'(SLOT_CTRL)) begin
        rd_val = ctrl_q;
      end else if (idx == IDX_W'(SLOT_STAT)) begin
        rd_val = stat_view;
      end else begin
        rd_val = gen_q[idx - IDX_W'(FIRST)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_req) begin
      rdata_q <= rd_val;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = pend_q;
endmodule

// File: rtl/fbc_regbank_chk.sv
module fbc_regbank_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 16,
  parameter int unsigned WIN    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              frame_done,
  input logic              irq,
  input logic [7:0]        ctrl_q
);
  logic stat_wr;
  logic rd;
  logic rd_stat;
  logic rd_out;

  always_comb begin
    stat_wr = bus_sel && bus_we && (bus_addr == ADDR_W'(BASE + 1));
    rd      = bus_sel && !bus_we;
    rd_stat = rd && (bus_addr == ADDR_W'(BASE + 1));
    rd_out  = rd && ((bus_addr < ADDR_W'(BASE)) || (32'(bus_addr) >= BASE + WIN));
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (!irq && bus_rdata == 8'h00));

  assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ctrl_q[7]) |=> irq);

  assert_masked_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !ctrl_q[7] && !irq) |=> !irq);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !frame_done) |=> !irq);

  assert_status_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (bus_rdata[6:1] == 6'b110000 && bus_rdata[0] && bus_rdata[7] == $past(irq)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && frame_done && ctrl_q[7]) |=> irq);

  assert_outside_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_out |=> (bus_rdata == 8'h00));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));

  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !frame_done) |=> !irq);
endmodule

bind fbc_regbank fbc_regbank_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .WIN(WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .frame_done(frame_done),
  .irq(irq), .ctrl_q(ctrl_q)
);

// File: tb/fbc_regbank_tb.sv
`timescale 1ns/1ps
module fbc_regbank_tb;
  logic       clk;
  logic       rst_n;
  logic       bus_sel;
  logic       bus_we;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       frame_done;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  string cur_req = "R1";

  // behavioural model
  int m_ctrl;
  int m_pend;
  int m_mem [16];
  int m_rdata;

  fbc_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_done(frame_done), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int model_read(int a);
    if (a < 16 || a > 31) return 0;
    if (a == 16) return m_ctrl;
    if (a == 17) return (m_pend != 0 ? 8'h80 : 8'h00) | 8'h61;
    return m_mem[a - 16];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model update and per-cycle comparison
  always @(posedge clk) begin
    int a;
    int raise;
    a = int'(bus_addr);
    if (!rst_n) begin
      m_ctrl = 0; m_pend = 0; m_rdata = 0;
      for (int i = 0; i < 16; i++) m_mem[i] = 0;
    end else begin
      raise = (frame_done && m_ctrl[7]) ? 1 : 0;
      if (bus_sel && !bus_we) m_rdata = model_read(a);
      if (bus_sel && bus_we) begin
        if (a == 16) m_ctrl = int'(bus_wdata);
        else if (a == 17) m_pend = 0;
        else if (a >= 18 && a <= 31) m_mem[a - 16] = int'(bus_wdata);
      end
      if (raise != 0) m_pend = 1;
    end
    #2;
    check({cur_req, " cycle irq"}, int'(irq), m_pend);
    check({cur_req, " cycle rdata"}, int'(bus_rdata), m_rdata);
  end

  task automatic idle();
    @(negedge clk);
    bus_sel = 0; bus_we = 0; frame_done = 0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = 8'(d); frame_done = 0;
    idle();
  endtask

  task automatic rd_check(string req, int a, int exp);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 8'(a); frame_done = 0;
    idle();
    check(req, int'(bus_rdata), exp);
  endtask

  task automatic frame();
    @(negedge clk);
    frame_done = 1;
    idle();
  endtask

  // bus write and frame pulse in the same cycle
  task automatic wr_with_frame(int a, int d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = 8'(d); frame_done = 1;
    idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; frame_done = 0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", int'(irq), 0);
    rst_n = 1;
    idle();

    cur_req = "R1";
    rd_check("R1 ctrl after reset", 16, 8'h00);
    rd_check("R1 status after reset", 17, 8'h61);
    rd_check("R1 byte 0x12 after reset", 18, 8'h00);
    rd_check("R1 byte 0x1F after reset", 31, 8'h00);

    cur_req = "R2";
    wr(16, 8'h5A); rd_check("R2 ctrl readback", 16, 8'h5A);
    wr(16, 8'h25); rd_check("R2 ctrl readback 2", 16, 8'h25);

    cur_req = "R4";
    frame();
    check("R4 irq stays low", int'(irq), 0);
    rd_check("R4 status unchanged", 17, 8'h61);

    cur_req = "R3";
    wr(16, 8'h80);
    frame();
    check("R3 irq raised", int'(irq), 1);
    cur_req = "R6";
    rd_check("R6 status pending", 17, 8'hE1);
    rd_check("R6 read no side effect", 17, 8'hE1);
    check("R6 irq after reads", int'(irq), 1);

    cur_req = "R5";
    wr(17, 8'h00);
    check("R5 ack data 00", int'(irq), 0);
    rd_check("R5 status after ack", 17, 8'h61);
    frame();
    wr(17, 8'hFF);
    check("R5 ack data FF", int'(irq), 0);
    rd_check("R5 data not stored", 17, 8'h61);
    wr(17, 8'h80);
    check("R5 ack when idle", int'(irq), 0);

    cur_req = "R7";
    for (int i = 18; i < 32; i++) wr(i, (i * 7 + 3) & 8'hFF);
    for (int i = 18; i < 32; i++) rd_check("R7 byte readback", i, (i * 7 + 3) & 8'hFF);
    wr(20, 8'hC3);
    rd_check("R7 neighbour below", 19, (19 * 7 + 3) & 8'hFF);
    rd_check("R7 neighbour above", 21, (21 * 7 + 3) & 8'hFF);
    rd_check("R7 ctrl untouched", 16, 8'h80);

    cur_req = "R8";
    frame();
    wr_with_frame(17, 8'h55);
    check("R8 set wins over ack", int'(irq), 1);
    wr(17, 0);
    wr_with_frame(17, 8'h00);
    check("R8 set wins from idle", int'(irq), 1);
    wr(17, 0);

    cur_req = "R11";
    wr_with_frame(16, 8'h00);
    check("R11 old enable used", int'(irq), 1);
    wr(17, 0);
    wr_with_frame(16, 8'h80);
    check("R11 new enable not used", int'(irq), 0);
    rd_check("R11 ctrl written", 16, 8'h80);

    cur_req = "R9";
    wr(5, 8'hFF); wr(32, 8'hFF); wr(255, 8'hFF);
    rd_check("R9 outside 0x05", 5, 0);
    rd_check("R9 outside 0x20", 32, 0);
    rd_check("R9 outside 0xFF", 255, 0);
    rd_check("R9 ctrl kept", 16, 8'h80);
    rd_check("R9 byte kept", 18, (18 * 7 + 3) & 8'hFF);

    cur_req = "R10";
    rd_check("R10 load", 21, (21 * 7 + 3) & 8'hFF);
    wr(22, 8'h11);
    idle(); idle();
    check("R10 rdata held", int'(bus_rdata), (21 * 7 + 3) & 8'hFF);

    cur_req = "R3";
    for (int n = 0; n < 400; n++) begin
      int r;
      int a;
      r = $urandom_range(0, 9);
      a = (r == 0) ? $urandom_range(0, 255) : $urandom_range(16, 31);
      @(negedge clk);
      bus_sel    = ($urandom_range(0, 2) != 0);
      bus_we     = ($urandom_range(0, 1) != 0);
      bus_addr   = 8'(a);
      bus_wdata  = 8'($urandom_range(0, 255));
      frame_done = ($urandom_range(0, 3) == 0);
    end
    idle();

    cur_req = "R1";
    wr(16, 8'h80); frame();
    check("R1 pending before reset", int'(irq), 1);
    @(negedge clk); rst_n = 0;
    #1 check("R1 irq drops in reset", int'(irq), 0);
    @(negedge clk); rst_n = 1;
    rd_check("R1 ctrl cleared", 16, 0);
    rd_check("R1 byte cleared", 18, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule